// File: doc/BRIEF.md
# DMA Controller Global Register Bank

This block is the shared control and interrupt register space of a multi-channel DMA controller. It sits on a simple register bus with byte offsets on an 8-byte stride. It holds three things: a global controller enable, a channel-enable register, and an interrupt bank with five event classes. The classes are transfer done, block done, source transaction, destination transaction and error. Each class has raw, masked-status, mask and clear registers, and a combined status register folds the classes into one interrupt line.

The channel datapaths live outside the block and connect through side inputs. They raise per-channel events, one pulse vector per class, and they drop their own enable bit when a transfer ends. Software turns a channel on or off by writing the channel-enable register. Each enable bit has a companion write-enable bit eight positions higher. Software shuts the controller down by writing the global enable to 0 and polling until it reads 0.

Top module: `dma_glbl_regs`

## Requirements
- R1: After a synchronous active-low reset:
  - every register reads 0;
  - `ch_en_o` is 0;
  - `dma_on_o` is 0;
  - `irq_o` is 0.
- R2: The channel-enable register is at 0x3A0. A write changes enable bit i (bits 7:0) only when data bit i+8 is 1. Bits whose write-enable bit is 0 keep their value.
- R3: While the stored global enable is 0, a write cannot set a channel-enable bit. Clearing a bit through its write-enable is still applied.
- R4: A pulse on `ch_done_i[i]` clears enable bit i on the next edge. If a software write to the same bit happens in the same cycle, the pulse wins.
- R5: The global configuration register is at 0x398, with the enable in bit 0. Bit 0 reads 1 while the stored enable is 1 or any channel-enable bit is set. `dma_on_o` carries the same value.
- R6: A pulse on event input bit k*NCH+i sets raw bit i of class k. The raw register of class k is at 0x2C0+8k, with classes in the order transfer, block, source, destination, error.
- R7: The mask of class k is read/write at 0x310+8k. The status register at 0x2E8+8k reads raw AND mask.
- R8: A write to 0x338+8k clears every raw bit of class k whose data bit is 1. The clear register reads 0.
- R9: When an event input sets a raw bit in the same cycle that a clear write targets it, the bit ends up set.
- R10: The combined register at 0x360 holds bit k = OR of the status bits of class k. `irq_o` is the OR of those five bits.
- R11: Writes to raw, status and combined registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (10) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational, 0 when not reading |
| ev_set_i | input | 5*NCH (40) | Event pulses, class k at bits k*NCH+i |
| ch_done_i | input | NCH (8) | Per-channel end-of-transfer pulses |
| ch_en_o | output | NCH (8) | Current channel-enable bits |
| dma_on_o | output | 1 | Global enable as it reads back |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of functions in this block can land on the same clock edge:
- **Event set against clear write.** The bench drives a transfer event on channel 0 at the same negative edge that it issues a clear write covering that bit and two other pending bits. It expects the channel 0 bit to survive and the other two bits to be gone.
- **End-of-transfer against software write.** The bench pulses `ch_done_i[0]` at the same time as a write that re-enables channel 0. It expects the bit to read 0, while channel 1 stays on.

// File: rtl/dgr_pkg.sv
// Package: shared constants of the DMA global register bank.
// Assumes byte offsets on an 8-byte stride. The class order is fixed because it selects the offsets.
package dgr_pkg;
    localparam int NCLS = 5;
    typedef enum int {CLS_XFER = 0, CLS_BLK = 1, CLS_SRC = 2, CLS_DST = 3, CLS_ERR = 4} evt_cls_e;
    localparam int STRIDE    = 8;
    localparam int RAW_BASE  = 'h2C0;
    localparam int STAT_BASE = 'h2E8;
    localparam int MASK_BASE = 'h310;
    localparam int CLR_BASE  = 'h338;
    localparam int COMB_OFF  = 'h360;
    localparam int CFG_OFF   = 'h398;
    localparam int CHEN_OFF  = 'h3A0;
endpackage

// File: rtl/dgr_evt_class.sv
// Module: one interrupt event class. Holds a raw bit per channel, a mask bit per channel,
// and drives status = raw & mask.
// Assumes the clear strobe and the set pulses come from different sources. When both hit the same bit, set wins.
module dgr_evt_class #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] stat_o
);
    logic [NCH-1:0] clr_bits;

    // Purpose: select which raw bits the current write acknowledges.
    always_comb clr_bits = clr_we ? wdata : '0;

    // Purpose: raw event latch, with set taking priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= (raw_o & ~clr_bits) | set_i;
    end

    // Purpose: software-owned enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '0;
        else if (mask_we) mask_o <= wdata;
    end

    // Purpose: masked status seen by software and the combiner.
    always_comb stat_o = raw_o & mask_o;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i))); // R9
    AST_CLR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_o & $past(wdata & ~set_i)) == '0)); // R8
endmodule

// File: rtl/dgr_chan_ctl.sv
// Module: global enable and channel-enable bits.
// Each enable bit moves only when its write-enable bit is present. Hardware done pulses override software.
// The global enable reads back as on while any channel is still enabled.
// Assumes NCH <= 8, because the write-enables sit eight bits above the enables.
module dgr_chan_ctl #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_bit,
    input  logic           chen_we,
    input  logic [NCH-1:0] en_bits,
    input  logic [NCH-1:0] we_bits,
    input  logic [NCH-1:0] done_i,
    output logic [NCH-1:0] ch_en_o,
    output logic           glb_rd_o
);
    logic glb_q;

    // Purpose: stored controller enable, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)      glb_q <= 1'b0;
        else if (cfg_we) glb_q <= cfg_bit;
    end

    // Purpose: one enable flop per channel, with the done pulse taking priority over the guarded write.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)                       ch_en_o[i] <= 1'b0;
            else if (done_i[i])               ch_en_o[i] <= 1'b0;
            else if (chen_we && we_bits[i])   ch_en_o[i] <= en_bits[i] & glb_q;
        end
    end

    // Purpose: readback of the enable, held on until all channels are idle.
    always_comb glb_rd_o = glb_q | (|ch_en_o);

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((ch_en_o & $past(done_i)) == '0)); // R4
    AST_NO_SET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_q |=> ((ch_en_o & ~$past(ch_en_o)) == '0)); // R3
    AST_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((ch_en_o ^ $past(ch_en_o)) & ~($past(we_bits) & {NCH{$past(chen_we)}}) & ~$past(done_i)) == '0)); // R2
endmodule

// File: rtl/dma_glbl_regs.sv
// Module: top of the DMA global register bank.
// It decodes the register bus, builds one event class per generate slice, returns read data
// combinationally and folds the status into one interrupt.
// Assumes a single-cycle bus: bus_sel with bus_wr is a write that takes effect on that edge.
module dma_glbl_regs
    import dgr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 10,
    parameter int DW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NCLS*NCH-1:0] ev_set_i,
    input  logic [NCH-1:0]      ch_done_i,
    output logic [NCH-1:0]      ch_en_o,
    output logic                dma_on_o,
    output logic                irq_o
);
    localparam int WE_POS = 8;

    logic           wr_go;
    logic           rd_go;
    logic [NCH-1:0] raw_a  [NCLS];
    logic [NCH-1:0] mask_a [NCLS];
    logic [NCH-1:0] stat_a [NCLS];
    logic [NCLS-1:0] comb;
    logic           unused_wbits;

    initial assert (NCH <= WE_POS && DW >= 2*WE_POS);

    // Purpose: qualify bus strobes.
    always_comb begin
        wr_go = bus_sel & bus_wr;
        rd_go = bus_sel & ~bus_wr;
    end

    assign unused_wbits = ^bus_wdata;

    // Purpose: one interrupt event class per slice, with mask and clear strobes decoded per class.
    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        logic mask_we_k;
        logic clr_we_k;
        assign mask_we_k = wr_go && (bus_addr == AW'(MASK_BASE + STRIDE*k));
        assign clr_we_k  = wr_go && (bus_addr == AW'(CLR_BASE + STRIDE*k));
        dgr_evt_class #(.NCH(NCH)) u_cls (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (ev_set_i[k*NCH +: NCH]),
            .mask_we (mask_we_k),
            .clr_we  (clr_we_k),
            .wdata   (bus_wdata[NCH-1:0]),
            .raw_o   (raw_a[k]),
            .mask_o  (mask_a[k]),
            .stat_o  (stat_a[k])
        );
        assign comb[k] = |stat_a[k];
    end

    dgr_chan_ctl #(.NCH(NCH)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wr_go && (bus_addr == AW'(CFG_OFF))),
        .cfg_bit  (bus_wdata[0]),
        .chen_we  (wr_go && (bus_addr == AW'(CHEN_OFF))),
        .en_bits  (bus_wdata[NCH-1:0]),
        .we_bits  (bus_wdata[WE_POS +: NCH]),
        .done_i   (ch_done_i),
        .ch_en_o  (ch_en_o),
        .glb_rd_o (dma_on_o)
    );

    // Purpose: single interrupt line from the per-class summaries.
    always_comb irq_o = |comb;

    // Purpose: combinational read mux over every mapped register.
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            for (int k = 0; k < NCLS; k++) begin
                if (bus_addr == AW'(RAW_BASE + STRIDE*k))  bus_rdata = DW'(raw_a[k]);
                if (bus_addr == AW'(STAT_BASE + STRIDE*k)) bus_rdata = DW'(stat_a[k]);
                if (bus_addr == AW'(MASK_BASE + STRIDE*k)) bus_rdata = DW'(mask_a[k]);
            end
            if (bus_addr == AW'(COMB_OFF)) bus_rdata = DW'(comb);
            if (bus_addr == AW'(CFG_OFF))  bus_rdata = DW'(dma_on_o);
            if (bus_addr == AW'(CHEN_OFF)) bus_rdata = DW'(ch_en_o);
        end
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(ev_set_i) != '0 || $past(wr_go))); // R10
endmodule

// File: tb/dma_glbl_regs_tb.sv
`timescale 1ns/1ps
module dma_glbl_regs_tb;
    localparam int NCH = 8;
    localparam int NT  = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5*NCH-1:0] ev_set = '0;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_en;
    logic        dma_on;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    dma_glbl_regs #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_set_i(ev_set), .ch_done_i(ch_done), .ch_en_o(ch_en),
        .dma_on_o(dma_on), .irq_o(irq)
    );

    // {write, addr, data (write data or expected read), requirement}
    localparam logic [46:0] TBL [0:NT-1] = '{
        {1'b1, 10'h398, 32'h1,    4'd5},   // R5 enable controller
        {1'b0, 10'h398, 32'h1,    4'd5},   // R5
        {1'b1, 10'h3A0, 32'h0305, 4'd2},   // R2 ch0 on, ch2 not enabled for write
        {1'b0, 10'h3A0, 32'h01,   4'd2},   // R2
        {1'b1, 10'h3A0, 32'h0C0E, 4'd2},   // R2 ch2,ch3 on, ch1 unguarded
        {1'b0, 10'h3A0, 32'h0D,   4'd2},   // R2
        {1'b1, 10'h310, 32'hA5,   4'd7},   // R7 transfer mask
        {1'b0, 10'h310, 32'hA5,   4'd7},   // R7
        {1'b1, 10'h320, 32'hFF,   4'd7},   // R7 source mask
        {1'b0, 10'h320, 32'hFF,   4'd7},   // R7
        {1'b1, 10'h398, 32'h0,    4'd5},   // R5 request off
        {1'b0, 10'h398, 32'h1,    4'd5},   // R5 still on, channels busy
        {1'b1, 10'h3A0, 32'h0F00, 4'd3},   // R3 clears apply while off
        {1'b0, 10'h3A0, 32'h0,    4'd3},   // R3
        {1'b0, 10'h398, 32'h0,    4'd5},   // R5 now off
        {1'b1, 10'h3A0, 32'h0101, 4'd3},   // R3 set attempt while off
        {1'b0, 10'h3A0, 32'h0,    4'd3},   // R3
        {1'b1, 10'h2C0, 32'hFF,   4'd11},  // R11 raw is read-only
        {1'b0, 10'h2C0, 32'h0,    4'd11},  // R11
        {1'b1, 10'h360, 32'h1F,   4'd11},  // R11 combined is read-only
        {1'b0, 10'h360, 32'h0,    4'd11},  // R11
        {1'b1, 10'h2E8, 32'hFF,   4'd11},  // R11 status is read-only
        {1'b0, 10'h2E8, 32'h0,    4'd11}   // R11
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus/side-input cycle driven at the falling edge, released at the next falling edge.
    task automatic step(input logic wr, input logic [9:0] a, input logic [31:0] d,
                        input logic [5*NCH-1:0] ev, input logic [NCH-1:0] dn);
        @(negedge clk);
        bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d; ev_set = ev; ch_done = dn;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_set = '0; ch_done = '0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 chk(bus_rdata, exp, req, $sformatf("read %h", a));
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(10'h398, 0, 1); rd(10'h3A0, 0, 1); rd(10'h2C0, 0, 1);
        rd(10'h310, 0, 1); rd(10'h360, 0, 1);
        chk({31'b0, irq}, 0, 1, "irq after reset");
        chk({31'b0, dma_on}, 0, 1, "dma_on after reset");
        chk({24'b0, ch_en}, 0, 1, "ch_en after reset");

        for (int t = 0; t < NT; t++) begin
            if (TBL[t][46]) step(1'b1, TBL[t][45:36], TBL[t][35:4], '0, '0);
            else            rd(TBL[t][45:36], TBL[t][35:4], int'(TBL[t][3:0]));
        end

        // R6 R7 R10 transfer events on ch0..3
        step(1'b0, 10'h0, 0, 40'h0F, '0);
        rd(10'h2C0, 32'h0F, 6); rd(10'h2E8, 32'h05, 7); rd(10'h360, 32'h01, 10);
        chk({31'b0, irq}, 1, 10, "irq with transfer status");
        // source class event ch4
        step(1'b0, 10'h0, 0, 40'h10 << 16, '0);
        rd(10'h2D0, 32'h10, 6); rd(10'h2F8, 32'h10, 7); rd(10'h360, 32'h05, 10);
        // error class event ch7, masked off
        step(1'b0, 10'h0, 0, 40'h80 << 32, '0);
        rd(10'h2E0, 32'h80, 6); rd(10'h308, 32'h0, 7); rd(10'h360, 32'h05, 10);

        // R8 acknowledge
        step(1'b1, 10'h338, 32'h05, '0, '0);
        rd(10'h2C0, 32'h0A, 8); rd(10'h2E8, 32'h00, 8); rd(10'h360, 32'h04, 8);
        rd(10'h338, 32'h0, 8);

        // R9 set and clear in the same cycle
        step(1'b1, 10'h338, 32'h0B, 40'h01, '0);
        rd(10'h2C0, 32'h01, 9); rd(10'h2E8, 32'h01, 9);

        // R10 all cleared drops irq
        step(1'b1, 10'h338, 32'h01, '0, '0);
        step(1'b1, 10'h348, 32'h10, '0, '0);
        step(1'b1, 10'h358, 32'h80, '0, '0);
        rd(10'h360, 32'h0, 10);
        chk({31'b0, irq}, 0, 10, "irq after all cleared");

        // R4 done pulses
        step(1'b1, 10'h398, 32'h1, '0, '0);
        step(1'b1, 10'h3A0, 32'h0303, '0, '0);
        rd(10'h3A0, 32'h03, 2);
        step(1'b1, 10'h3A0, 32'h0101, '0, 8'h01);
        rd(10'h3A0, 32'h02, 4);
        chk({24'b0, ch_en}, 32'h02, 4, "ch_en after done vs write");
        step(1'b0, 10'h0, 0, '0, 8'h02);
        rd(10'h3A0, 32'h0, 4);
        chk({31'b0, dma_on}, 1, 5, "dma_on while enabled");
        step(1'b1, 10'h398, 32'h0, '0, '0);
        chk({31'b0, dma_on}, 0, 5, "dma_on after off, idle");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule